// File: doc/BRIEF.md
# Preferred-Thread Issue Slot Allocator

This block decides, every clock cycle, which hardware thread owns each issue slot of a multi-issue core that runs several threads at once. Each thread presents a count of instructions ready to issue and a stall flag. A configuration register selects one favoured thread. That thread claims slots first. Any slots it cannot fill are handed to the remaining threads. One cycle can therefore carry instructions from several threads.

The outputs are a valid bit and an owning thread ID for each slot, plus a grant count for each thread. The upstream instruction queues use the grant counts to dequeue. Grants and slot ownership are combinational from the ready counts, the stall flags and two small pieces of state: the favoured-thread register and a rotating start pointer. The start pointer decides which non-favoured thread is offered leftover slots first. It moves on by one thread every cycle, so back-filling is shared over time.

Top module: `pts_issue_alloc`

## Requirements
- R1: When the favoured thread is not stalled, it is granted min(its ready count, issue width) slots, and those slots occupy slot 0 upward.
- R2: A ready count above the issue width is treated as equal to the issue width.
- R3: Leftover slots go to the non-favoured threads in round-robin order, starting at the thread named by a start pointer and skipping the favoured thread. Each thread takes as many as it has ready. The pointer is 0 after reset and advances by one, modulo the thread count, on every clock edge.
- R4: While the favoured thread is stalled, it receives no slots and every slot is offered to the other threads. Once the stall clears, it reclaims its slots in that same cycle.
- R5: A stalled thread, favoured or not, is granted zero slots.
- R6: No thread is granted more than its ready count. The grants sum to at most the issue width. The number of valid slots equals that sum.
- R7: Valid slots are contiguous from slot 0. A slot with no owner has valid 0 and thread ID 0. With no ready work, no slot is valid and every grant is 0.
- R8: The favoured-thread register resets to thread 0. A write takes effect on the clock edge that samples it, so it changes the allocation from the next cycle on and not in the cycle of the write.
- R9: Packed fields: the ready count and grant count of thread t sit at bits [t*CW +: CW], where CW = clog2(issue width + 1). The owner of slot s sits at bits [s*TW +: TW], where TW = clog2(thread count).
- R10: Grants and slot ownership respond to ready counts and stall flags in the same cycle, with no register on that path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ready_cnt | input | NUM_THREADS*CW | Per-thread ready instruction counts |
| stall | input | NUM_THREADS | Per-thread stall flags |
| pref_wr_en | input | 1 | Write strobe for the favoured-thread register |
| pref_wr_id | input | TW | Thread ID written into the favoured-thread register |
| slot_valid | output | ISSUE_W | Slot holds an instruction this cycle |
| slot_tid | output | ISSUE_W*TW | Owning thread of each slot |
| grant_cnt | output | NUM_THREADS*CW | Slots granted to each thread |

## Verification
Slot ownership and grant counts are due in the same cycle as the ready and stall inputs that produce them. The bench therefore drives those inputs just after a falling edge and samples 5 ns later, before the next rising edge. A write to the favoured-thread register is due one rising edge after the strobe. The bench checks the old owner in the write cycle and the new owner in the following cycle. The start pointer moves on every rising edge, and the bench keeps its own count of edges since reset. It applies a table row only when that count matches the pointer value the row was worked out for.

// File: rtl/pts_pkg.sv
// Package pts_pkg
// Purpose : integer helpers shared by the issue slot allocator modules.
// Assumes : arguments are non-negative and moduli are greater than zero.
package pts_pkg;

    // Smaller of two integers.
    function automatic int min_int(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // (base + step) reduced modulo n.
    function automatic int wrap_add(input int base, input int step, input int n);
        return (base + step) % n;
    endfunction

endpackage

// File: rtl/pts_pref_reg.sv
// Module  : pts_pref_reg
// Purpose : holds the ID of the favoured thread. A write is captured on the
//           clock edge that samples the strobe.
// Assumes : synchronous active-low reset; IDs at or above NUM_THREADS are
//           dropped.
module pts_pref_reg #(
    parameter int NUM_THREADS = 4,
    parameter int TW          = $clog2(NUM_THREADS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [TW-1:0] wr_id,
    output logic [TW-1:0] pref_q
);

    // Register update: reset to thread 0, then load legal IDs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pref_q <= '0;
        end else if (wr_en && (int'(wr_id) < NUM_THREADS)) begin
            pref_q <= wr_id;
        end
    end

endmodule

// File: rtl/pts_rr_ptr.sv
// Module  : pts_rr_ptr
// Purpose : start pointer for back-filling. It names the first non-favoured
//           thread offered leftover slots and steps by one every cycle.
// Assumes : synchronous active-low reset; NUM_THREADS >= 2.
module pts_rr_ptr #(
    parameter int NUM_THREADS = 4,
    parameter int TW          = $clog2(NUM_THREADS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [TW-1:0] rr_q
);

    // Step the pointer modulo the thread count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else begin
            rr_q <= TW'(pts_pkg::wrap_add(int'(rr_q), 1, NUM_THREADS));
        end
    end

endmodule

// File: rtl/pts_grant_calc.sv
// Module  : pts_grant_calc
// Purpose : computes the per-thread slot grants. The favoured thread is served
//           first, then the other threads in rotating order from rr.
// Assumes : purely combinational; ready counts may exceed ISSUE_W and are
//           clamped here.
module pts_grant_calc #(
    parameter int NUM_THREADS = 4,
    parameter int ISSUE_W     = 4,
    parameter int CW          = $clog2(ISSUE_W + 1),
    parameter int TW          = $clog2(NUM_THREADS)
) (
    input  logic [NUM_THREADS*CW-1:0] ready_cnt,
    input  logic [NUM_THREADS-1:0]    stall,
    input  logic [TW-1:0]             pref,
    input  logic [TW-1:0]             rr,
    output logic [NUM_THREADS*CW-1:0] grant_cnt
);

    int eff [NUM_THREADS];
    int remain;
    int take;
    int tid;

    // Clamp each request, serve the favoured thread, then back-fill in rotation.
    always_comb begin
        grant_cnt = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            eff[t] = stall[t] ? 0
                   : pts_pkg::min_int(int'(ready_cnt[t*CW +: CW]), ISSUE_W);
        end
        take   = eff[int'(pref)];
        remain = ISSUE_W - take;
        grant_cnt[int'(pref)*CW +: CW] = CW'(take);
        for (int k = 0; k < NUM_THREADS; k++) begin
            tid = pts_pkg::wrap_add(int'(rr), k, NUM_THREADS);
            if (tid != int'(pref)) begin
                take   = pts_pkg::min_int(eff[tid], remain);
                remain = remain - take;
                grant_cnt[tid*CW +: CW] = CW'(take);
            end
        end
    end

endmodule

// File: rtl/pts_slot_map.sv
// Module  : pts_slot_map
// Purpose : turns grant counts into slot ownership. The favoured thread's
//           slots come first, then the other threads in rotating order from rr.
//           All assignments are contiguous from slot 0.
// Assumes : grants sum to at most ISSUE_W; purely combinational.
module pts_slot_map #(
    parameter int NUM_THREADS = 4,
    parameter int ISSUE_W     = 4,
    parameter int CW          = $clog2(ISSUE_W + 1),
    parameter int TW          = $clog2(NUM_THREADS)
) (
    input  logic [NUM_THREADS*CW-1:0] grant_cnt,
    input  logic [TW-1:0]             pref,
    input  logic [TW-1:0]             rr,
    output logic [ISSUE_W-1:0]        slot_valid,
    output logic [ISSUE_W*TW-1:0]     slot_tid
);

    int pos;
    int tid;
    int cnt;

    // Walk the service order and lay each thread's grants into the next free slots.
    always_comb begin
        slot_valid = '0;
        slot_tid   = '0;
        pos        = 0;
        for (int k = 0; k <= NUM_THREADS; k++) begin
            if (k == 0) begin
                tid = int'(pref);
            end else begin
                tid = pts_pkg::wrap_add(int'(rr), k - 1, NUM_THREADS);
            end
            cnt = int'(grant_cnt[tid*CW +: CW]);
            if ((k == 0) || (tid != int'(pref))) begin
                for (int j = 0; j < ISSUE_W; j++) begin
                    if ((j < cnt) && (pos < ISSUE_W)) begin
                        slot_valid[pos]         = 1'b1;
                        slot_tid[pos*TW +: TW]  = TW'(tid);
                        pos                     = pos + 1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/pts_issue_alloc.sv
// Module  : pts_issue_alloc
// Purpose : top of the favoured-thread issue slot allocator. It ties together
//           the favoured-thread register, the rotating start pointer, the grant
//           calculation and the slot mapping, and checks their joint behaviour.
// Assumes : synchronous active-low reset; NUM_THREADS >= 2; outputs are
//           combinational from ready_cnt and stall.
module pts_issue_alloc #(
    parameter int NUM_THREADS = 4,
    parameter int ISSUE_W     = 4,
    localparam int CW         = $clog2(ISSUE_W + 1),
    localparam int TW         = $clog2(NUM_THREADS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_THREADS*CW-1:0] ready_cnt,
    input  logic [NUM_THREADS-1:0]    stall,
    input  logic                      pref_wr_en,
    input  logic [TW-1:0]             pref_wr_id,
    output logic [ISSUE_W-1:0]        slot_valid,
    output logic [ISSUE_W*TW-1:0]     slot_tid,
    output logic [NUM_THREADS*CW-1:0] grant_cnt
);

    logic [TW-1:0] pref_q;
    logic [TW-1:0] rr_q;

    pts_pref_reg #(.NUM_THREADS(NUM_THREADS), .TW(TW)) u_pref (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (pref_wr_en),
        .wr_id  (pref_wr_id),
        .pref_q (pref_q)
    );

    pts_rr_ptr #(.NUM_THREADS(NUM_THREADS), .TW(TW)) u_rr (
        .clk   (clk),
        .rst_n (rst_n),
        .rr_q  (rr_q)
    );

    pts_grant_calc #(
        .NUM_THREADS(NUM_THREADS), .ISSUE_W(ISSUE_W), .CW(CW), .TW(TW)
    ) u_grant (
        .ready_cnt (ready_cnt),
        .stall     (stall),
        .pref      (pref_q),
        .rr        (rr_q),
        .grant_cnt (grant_cnt)
    );

    pts_slot_map #(
        .NUM_THREADS(NUM_THREADS), .ISSUE_W(ISSUE_W), .CW(CW), .TW(TW)
    ) u_map (
        .grant_cnt  (grant_cnt),
        .pref       (pref_q),
        .rr         (rr_q),
        .slot_valid (slot_valid),
        .slot_tid   (slot_tid)
    );

    int grant_sum;

    // Total of all grants, compared against the number of valid slots.
    always_comb begin
        grant_sum = 0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            grant_sum = grant_sum + int'(grant_cnt[t*CW +: CW]);
        end
    end

    // R6: valid slot count matches the grants, and never exceeds the width.
    p_slot_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(slot_valid) == grant_sum) && (grant_sum <= ISSUE_W));

    // R1: a ready, unstalled favoured thread always owns slot 0.
    p_pref_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall[pref_q] && (ready_cnt[int'(pref_q)*CW +: CW] != '0))
        |-> (slot_valid[0] && (slot_tid[TW-1:0] == pref_q)));

    // R8: a write seen by the register shows up on the following cycle.
    p_pref_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pref_wr_en && rst_n && (int'(pref_wr_id) < NUM_THREADS))
        |-> (pref_q == $past(pref_wr_id)));

    generate
        for (genvar gt = 0; gt < NUM_THREADS; gt++) begin : g_thr_chk
            // R6: no thread receives more than it asked for.
            p_grant_le_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
                grant_cnt[gt*CW +: CW] <= ready_cnt[gt*CW +: CW]);
            // R5: stalled threads get nothing.
            p_stall_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
                stall[gt] |-> (grant_cnt[gt*CW +: CW] == '0));
        end
        for (genvar gs = 0; gs < ISSUE_W - 1; gs++) begin : g_slot_chk
            // R7: a valid slot never follows an empty one.
            p_contig_r7: assert property (@(posedge clk) disable iff (!rst_n)
                slot_valid[gs+1] |-> slot_valid[gs]);
        end
        for (genvar ge = 0; ge < ISSUE_W; ge++) begin : g_empty_chk
            // R7: an empty slot reports thread 0.
            p_empty_tid_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !slot_valid[ge] |-> (slot_tid[ge*TW +: TW] == '0));
        end
    endgenerate

endmodule

// File: tb/pts_issue_alloc_tb.sv
// Bench for pts_issue_alloc at default parameters (4 threads, 4 slots).
module pts_issue_alloc_tb_top;

    localparam int NT = 4;
    localparam int IW = 4;
    localparam int CW = 3;
    localparam int TW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NT*CW-1:0]  ready_cnt = '0;
    logic [NT-1:0]     stall = '0;
    logic              pref_wr_en = 1'b0;
    logic [TW-1:0]     pref_wr_id = '0;
    logic [IW-1:0]     slot_valid;
    logic [IW*TW-1:0]  slot_tid;
    logic [NT*CW-1:0]  grant_cnt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int rr_m   = 0;

    // 50 MHz clock.
    always #10 clk = ~clk;

    pts_issue_alloc dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ready_cnt  (ready_cnt),
        .stall      (stall),
        .pref_wr_en (pref_wr_en),
        .pref_wr_id (pref_wr_id),
        .slot_valid (slot_valid),
        .slot_tid   (slot_tid),
        .grant_cnt  (grant_cnt)
    );

    // Model of the start pointer from R3: 0 in reset, +1 mod 4 per edge.
    always @(posedge clk) begin
        if (!rst_n) rr_m <= 0;
        else        rr_m <= (rr_m + 1) % NT;
    end

    // Table row. Packed arrays are listed thread 3 (or slot 3) first; owner 4 = empty.
    typedef struct packed {
        logic [1:0]      pref;
        logic [1:0]      rr;
        logic [3:0]      stl;
        logic [3:0][2:0] rdy;
        logic [3:0][2:0] gnt;
        logic [3:0][2:0] own;
    } row_t;

    localparam int NROWS = 9;
    localparam row_t ROWS [NROWS] = '{
        '{2'd0, 2'd0, 4'b0000, {3'd1,3'd1,3'd1,3'd2}, {3'd0,3'd1,3'd1,3'd2}, {3'd2,3'd1,3'd0,3'd0}},
        '{2'd0, 2'd2, 4'b0000, {3'd1,3'd1,3'd1,3'd2}, {3'd1,3'd1,3'd0,3'd2}, {3'd3,3'd2,3'd0,3'd0}},
        '{2'd1, 2'd1, 4'b0000, {3'd0,3'd2,3'd1,3'd3}, {3'd0,3'd2,3'd1,3'd1}, {3'd0,3'd2,3'd2,3'd1}},
        '{2'd2, 2'd3, 4'b0100, {3'd1,3'd4,3'd2,3'd2}, {3'd1,3'd0,3'd1,3'd2}, {3'd1,3'd0,3'd0,3'd3}},
        '{2'd3, 2'd0, 4'b0000, {3'd7,3'd2,3'd2,3'd2}, {3'd4,3'd0,3'd0,3'd0}, {3'd3,3'd3,3'd3,3'd3}},
        '{2'd0, 2'd1, 4'b0010, {3'd2,3'd2,3'd3,3'd1}, {3'd1,3'd2,3'd0,3'd1}, {3'd3,3'd2,3'd2,3'd0}},
        '{2'd1, 2'd2, 4'b0000, {3'd0,3'd1,3'd1,3'd0}, {3'd0,3'd1,3'd1,3'd0}, {3'd4,3'd4,3'd2,3'd1}},
        '{2'd2, 2'd3, 4'b1111, {3'd3,3'd3,3'd3,3'd3}, {3'd0,3'd0,3'd0,3'd0}, {3'd4,3'd4,3'd4,3'd4}},
        '{2'd3, 2'd1, 4'b0000, {3'd0,3'd1,3'd1,3'd4}, {3'd0,3'd1,3'd1,3'd2}, {3'd0,3'd0,3'd2,3'd1}}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic write_pref(input int id);
        @(negedge clk);
        pref_wr_en = 1'b1;
        pref_wr_id = TW'(id);
        @(negedge clk);
        pref_wr_en = 1'b0;
    endtask

    function automatic logic [NT*CW-1:0] all_ready(input int n);
        logic [NT*CW-1:0] v = '0;
        for (int t = 0; t < NT; t++) v[t*CW +: CW] = CW'(n);
        return v;
    endfunction

    initial begin
        logic [IW-1:0]    ev;
        logic [IW*TW-1:0] et;
        // Reset: no ready work, so nothing valid and nothing granted (R7).
        repeat (3) @(negedge clk);
        #5;
        check("R7", "slot_valid in reset", 32'(slot_valid), 32'h0);
        check("R7", "grant_cnt in reset", 32'(grant_cnt), 32'h0);
        rst_n = 1'b1;

        // R8: favoured register comes out of reset as thread 0.
        @(negedge clk);
        ready_cnt = all_ready(1);
        #5;
        check("R8", "slot0 owner after reset", 32'(slot_tid[1:0]), 32'd0);
        check("R1", "favoured grant after reset", 32'(grant_cnt[2:0]), 32'd1);

        // R10: a ready change is reflected before any clock edge.
        @(negedge clk);
        ready_cnt[2:0] = 3'd3;
        #2;
        check("R10", "grant t0 same cycle", 32'(grant_cnt[2:0]), 32'd3);
        check("R10", "slots 0-2 owned by t0", 32'(slot_tid[5:0]), 32'h0);

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R9.
        for (int i = 0; i < NROWS; i++) begin
            write_pref(int'(ROWS[i].pref));
            while (rr_m != int'(ROWS[i].rr)) @(negedge clk);
            for (int t = 0; t < NT; t++) ready_cnt[t*CW +: CW] = ROWS[i].rdy[t];
            stall = ROWS[i].stl;
            #5;
            for (int s = 0; s < IW; s++) begin
                ev[s]           = (ROWS[i].own[s] != 3'd4);
                et[s*TW +: TW]  = ev[s] ? ROWS[i].own[s][1:0] : 2'd0;
            end
            check("R1/R3/R6", $sformatf("row %0d grants", i), 32'(grant_cnt), 32'(ROWS[i].gnt));
            check("R7/R9", $sformatf("row %0d slot_valid", i), 32'(slot_valid), 32'(ev));
            check("R7/R9", $sformatf("row %0d slot_tid", i), 32'(slot_tid), 32'(et));
        end

        // R8: write takes effect only after the sampling edge.
        stall = '0;
        write_pref(1);
        @(negedge clk);
        ready_cnt  = all_ready(1);
        pref_wr_en = 1'b1;
        pref_wr_id = 2'd2;
        #5;
        check("R8", "slot0 owner in write cycle", 32'(slot_tid[1:0]), 32'd1);
        @(negedge clk);
        pref_wr_en = 1'b0;
        #5;
        check("R8", "slot0 owner after write", 32'(slot_tid[1:0]), 32'd2);

        // R4: favoured thread 2 stalled over several cycles, others fill.
        @(negedge clk);
        ready_cnt = all_ready(1);
        ready_cnt[2*CW +: CW] = 3'd4;
        stall = 4'b0100;
        for (int c = 0; c < 3; c++) begin
            #5;
            check("R4", "stalled favoured grant", 32'(grant_cnt[2*CW +: CW]), 32'd0);
            check("R4", "others fill slots", 32'(slot_valid), 32'b0111);
            @(negedge clk);
        end
        stall = '0;
        #5;
        check("R4", "favoured reclaims on clear", 32'(grant_cnt[2*CW +: CW]), 32'd4);

        // R3: favoured 0 idle; whole width goes to first non-favoured from pointer.
        write_pref(0);
        for (int c = 0; c < NT; c++) begin
            int first;
            @(negedge clk);
            ready_cnt = all_ready(4);
            ready_cnt[2:0] = 3'd0;
            #5;
            first = (rr_m == 0) ? 1 : rr_m;
            check("R3", $sformatf("rotation start rr=%0d", rr_m),
                  32'(grant_cnt[first*CW +: CW]), 32'd4);
            check("R3", "rotation slot0 owner", 32'(slot_tid[1:0]), 32'(first));
        end

        // R5/R7: everything stalled gives an empty issue group.
        @(negedge clk);
        stall = 4'b1111;
        #5;
        check("R5", "all stalled grants", 32'(grant_cnt), 32'h0);
        check("R7", "all stalled slots", 32'(slot_valid), 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        #4000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule